// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps a processor core in reset after a power-on event, a brown-out event or an external reset request. After a power-on or brown-out request clears, it runs up to two timers in a fixed order: a power-up delay measured in ticks of a slow clock-enable, then an oscillator settling count of 1024 clock periods. The core is released only when both enabled stages are over and the external reset pin is high.

Which stages run depends on the oscillator mode field and on an active-low enable bit for the power-up delay. The timers run whether or not the external pin is low. A pin held low past both time-outs therefore releases the core almost at once when it goes high. A two-bit reset-cause register keeps sticky power-on and brown-out flags. Software can overwrite these flags, and reset events clear them.

The power-on request resets the block asynchronously. The brown-out and pin inputs pass through a two-flop synchronizer. The power-on request leaves its own synchronizer through the same two flops.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_req` is high, `core_rst` is 1 and `seq_done` is 0 without waiting for a clock edge. The `cause` register reads 2'b00.
- R2: The power-up stage advances only in cycles where `slow_tick` is 1. It ends after `PWRT_TICKS` such cycles. While `slow_tick` stays 0 the core stays in reset.
- R3: The settling stage counts `OST_CYCLES` (1024) clock cycles and always follows the power-up stage. It runs only for crystal modes, which are `osc_mode` values 0, 1 and 2. Values 3 to 7 (external clock, internal oscillator, RC) skip it.
- R4: `pwrt_dis`=1 skips the power-up stage and `pwrt_dis`=0 runs it. With `ext_rst_n` high and `slow_tick` held at 1, `core_rst` stays high for exactly 3 + `PWRT_TICKS`·(`pwrt_dis`==0) + `OST_CYCLES`·(crystal mode) clock cycles after `por_req` falls. For mode 3 with `pwrt_dis`=1 this is 3 cycles, with no time-out.
- R5: The time-outs run while `ext_rst_n` is low. If the pin rises after they are over, `core_rst` falls on the third clock edge after the rise.
- R6: A low on `ext_rst_n` during normal running raises `core_rst` from the third clock edge on. When the pin returns high, `core_rst` falls on the third edge after the rise, and no timer runs.
- R7: A `bor_req` held for at least two cycles during any stage restarts the sequence from the start. `core_rst` then stays high for the R4 count measured from the fall of `bor_req`.
- R8: `seq_done` is a one-cycle pulse. It is high in the first cycle in which `core_rst` is 0.
- R9: In the `cause` register, bit 0 is the power-on flag and bit 1 is the brown-out flag. When `cause_wr` is 1, `cause_wdata` is loaded into both bits at the next edge.
- R10: A power-on request clears both flags. A brown-out clears only bit 1. An external pin reset changes neither flag.
- R11: A reset event in the same cycle as a software write wins. The write is dropped, so a brown-out leaves bit 1 at 0 even while writes of 1 continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_req | input | 1 | Raw power-on request, active high, asynchronous |
| bor_req | input | 1 | Raw brown-out request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| slow_tick | input | 1 | Clock enable that paces the power-up stage |
| osc_mode | input | 3 | Oscillator mode; 0 to 2 are crystal modes |
| pwrt_dis | input | 1 | 1 skips the power-up stage, 0 runs it |
| cause_wr | input | 1 | Software write strobe for the cause register |
| cause_wdata | input | 2 | Software write data for the cause register |
| cause | output | 2 | Reset-cause flags: bit 0 power-on, bit 1 brown-out |
| core_rst | output | 1 | Reset to the core, active high |
| seq_done | output | 1 | One-cycle pulse when the core leaves reset |

## Verification
Two functions can act in the same cycle: the software load of the cause register and the clearing of the brown-out flag by a synchronized brown-out event. The bench raises `bor_req` together with a continuous stream of writes of 2'b11, in the middle of the settling stage. Because of the synchronizer delay, the first writes land and later writes coincide with the event. The bench judges the outcome by the value read back after the event, which must be 2'b01. It then counts the restart latency from the fall of `bor_req`, which must equal the full R4 count.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_PWRT,
    ST_OST,
    ST_HOLD,
    ST_RUN
  } seq_st_e;

  // Modes 0..2 drive a crystal and need the settling count.
  function automatic logic osc_needs_ost(logic [MODE_W-1:0] m);
    return m < MODE_W'(3);
  endfunction

  function automatic int cnt_width(int a, int b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction
endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pwrup_cause.sv
module pwrup_cause (
  input  logic       clk,
  input  logic       arst,
  input  logic       por_s,
  input  logic       bor_s,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic [1:0] cause
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)       cause <= 2'b00;
    else if (por_s) cause <= 2'b00;
    else if (bor_s) cause[1] <= 1'b0;
    else if (wr)    cause <= wdata;
  end
endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 64,
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic arst,
  input  logic restart,
  input  logic ext_s,
  input  logic slow_tick,
  input  logic xtal,
  input  logic pwrt_dis,
  output logic core_rst,
  output logic seq_done,
  output logic in_ost
);
  localparam int CW = cnt_width(PWRT_TICKS, OST_CYCLES);
  localparam logic [CW-1:0] PW_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OS_LAST = CW'(OST_CYCLES - 1);

  seq_st_e       st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          done_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    done_n = 1'b0;
    if (restart) begin
      st_n  = ST_ARM;
      cnt_n = '0;
    end else begin
      unique case (st)
        ST_ARM: begin
          cnt_n = '0;
          if (!pwrt_dis) st_n = ST_PWRT;
          else           st_n = xtal ? ST_OST : ST_HOLD;
        end
        ST_PWRT: if (slow_tick) begin
          if (cnt == PW_LAST) begin
            cnt_n = '0;
            st_n  = xtal ? ST_OST : ST_HOLD;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_OST: begin
          if (cnt == OS_LAST) begin
            cnt_n = '0;
            st_n  = ST_HOLD;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_HOLD: if (ext_s) begin
          st_n   = ST_RUN;
          done_n = 1'b1;
        end
        ST_RUN: if (!ext_s) st_n = ST_HOLD;
        default: st_n = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      st       <= ST_ARM;
      cnt      <= '0;
      seq_done <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      seq_done <= done_n;
    end
  end

  assign core_rst = (st != ST_RUN);
  assign in_ost   = (st == ST_OST);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 64,
  parameter int OST_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              bor_req,
  input  logic              ext_rst_n,
  input  logic              slow_tick,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              pwrt_dis,
  input  logic              cause_wr,
  input  logic [1:0]        cause_wdata,
  output logic [1:0]        cause,
  output logic              core_rst,
  output logic              seq_done
);
  logic [2:0] sync_q;
  logic       por_s, bor_s, ext_s, restart, xtal, in_ost;

  // bit 0: power-on (resets to 1), bit 1: brown-out, bit 2: pin level
  pwrup_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk (clk),
    .arst(por_req),
    .d   ({ext_rst_n, bor_req, 1'b0}),
    .q   (sync_q)
  );

  assign por_s   = sync_q[0];
  assign bor_s   = sync_q[1];
  assign ext_s   = sync_q[2];
  assign restart = por_s | bor_s;
  assign xtal    = osc_needs_ost(osc_mode);

  pwrup_seq_fsm #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) u_fsm (
    .clk      (clk),
    .arst     (por_req),
    .restart  (restart),
    .ext_s    (ext_s),
    .slow_tick(slow_tick),
    .xtal     (xtal),
    .pwrt_dis (pwrt_dis),
    .core_rst (core_rst),
    .seq_done (seq_done),
    .in_ost   (in_ost)
  );

  pwrup_cause u_cause (
    .clk  (clk),
    .arst (por_req),
    .por_s(por_s),
    .bor_s(bor_s),
    .wr   (cause_wr),
    .wdata(cause_wdata),
    .cause(cause)
  );
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       por_s,
  input logic       bor_s,
  input logic       ext_s,
  input logic       restart,
  input logic       xtal,
  input logic       in_ost,
  input logic       core_rst,
  input logic       seq_done,
  input logic [1:0] cause
);
  a_r7_restart_holds: assert property (@(posedge clk) disable iff (por_req)
    restart |=> core_rst);

  a_r3_ost_only_xtal: assert property (@(posedge clk) disable iff (por_req)
    $rose(in_ost) |-> $past(xtal));

  a_r5_release_needs_pin: assert property (@(posedge clk) disable iff (por_req)
    $fell(core_rst) |-> $past(ext_s));

  a_r6_pin_low_resets: assert property (@(posedge clk) disable iff (por_req)
    !ext_s |=> core_rst);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (por_req)
    seq_done |=> !seq_done);

  a_r8_done_in_run: assert property (@(posedge clk) disable iff (por_req)
    seq_done |-> !core_rst);

  a_r10_bor_clears: assert property (@(posedge clk) disable iff (por_req)
    bor_s |=> !cause[1]);

  a_r10_por_clears: assert property (@(posedge clk) disable iff (por_req)
    por_s |=> (cause == 2'b00));
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk     (clk),
  .por_req (por_req),
  .por_s   (por_s),
  .bor_s   (bor_s),
  .ext_s   (ext_s),
  .restart (restart),
  .xtal    (xtal),
  .in_ost  (in_ost),
  .core_rst(core_rst),
  .seq_done(seq_done),
  .cause   (cause)
);

// File: tb/sim_pwrup_seq.sv
`timescale 1ns/100ps
module sim_pwrup_seq;
  localparam int PW   = 64;
  localparam int OS   = 1024;
  localparam int BASE = 3;
  localparam int NV   = 10;
  localparam int WD   = 200000;

  // {mode[2:0], pwrt_dis}
  localparam logic [3:0] VEC_IN [NV] = '{
    4'b000_0, 4'b001_1, 4'b010_0, 4'b011_1, 4'b011_0,
    4'b100_1, 4'b110_0, 4'b111_1, 4'b101_0, 4'b001_0};
  localparam int VEC_EXP [NV] = '{
    BASE+PW+OS, BASE+OS, BASE+PW+OS, BASE, BASE+PW,
    BASE, BASE+PW, BASE, BASE+PW, BASE+PW+OS};

  logic       clk = 1'b0;
  logic       por_req = 1'b1;
  logic       bor_req = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       slow_tick = 1'b1;
  logic [2:0] osc_mode = 3'd3;
  logic       pwrt_dis = 1'b1;
  logic       cause_wr = 1'b0;
  logic [1:0] cause_wdata = 2'b00;
  logic [1:0] cause;
  logic       core_rst, seq_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pwrup_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OS)) u0 (
    .clk(clk), .por_req(por_req), .bor_req(bor_req), .ext_rst_n(ext_rst_n),
    .slow_tick(slow_tick), .osc_mode(osc_mode), .pwrt_dis(pwrt_dis),
    .cause_wr(cause_wr), .cause_wdata(cause_wdata), .cause(cause),
    .core_rst(core_rst), .seq_done(seq_done));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Count samples with core_rst high, one per cycle, from the next negedge.
  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!core_rst) break;
      n++;
    end
  endtask

  task automatic check_release(input string req, input int exp);
    int n;
    count_high(n);
    chk(req, n, exp);
    chk("R8 done pulse", int'(seq_done), 1);
    @(negedge clk);
    chk("R8 done clears", int'(seq_done), 0);
  endtask

  task automatic power_on(input logic [2:0] m, input logic dis);
    @(negedge clk);
    osc_mode = m;
    pwrt_dis = dis;
    por_req  = 1'b1;
    #1;
    chk("R1 core_rst on por", int'(core_rst), 1);
    chk("R1 cause on por", int'(cause), 0);
    repeat (3) @(negedge clk);
    chk("R1 done low in por", int'(seq_done), 0);
    por_req = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= WD) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
        finish_run();
      end
    end
  end

  initial begin
    int n;
    // Table walk: R3 and R4 latency for each mode and enable setting
    for (int v = 0; v < NV; v++) begin
      power_on(VEC_IN[v][3:1], VEC_IN[v][0]);
      check_release($sformatf("R4/R3 vector %0d latency", v), VEC_EXP[v]);
    end

    // R9: software write and readback
    @(negedge clk);
    cause_wr = 1'b1; cause_wdata = 2'b11;
    @(negedge clk);
    cause_wr = 1'b0;
    chk("R9 write readback", int'(cause), 3);

    // R6: pin low during run, then high again with no timer
    ext_rst_n = 1'b0;
    @(negedge clk); chk("R6 still running edge1", int'(core_rst), 0);
    @(negedge clk); chk("R6 still running edge2", int'(core_rst), 0);
    @(negedge clk); chk("R6 reset at edge3", int'(core_rst), 1);
    repeat (5) @(negedge clk);
    ext_rst_n = 1'b1;
    check_release("R6 pin release latency", 2);
    chk("R10 pin reset keeps cause", int'(cause), 3);

    // R10: power-on clears both flags
    power_on(3'd3, 1'b1);
    #1;
    chk("R10 por clears cause", int'(cause), 0);
    check_release("R4 no time-out", BASE);

    // R5: pin held low past the time-outs
    ext_rst_n = 1'b0;
    power_on(3'd2, 1'b0);
    repeat (BASE + PW + OS + 40) @(negedge clk);
    chk("R5 held by pin", int'(core_rst), 1);
    ext_rst_n = 1'b1;
    check_release("R5 immediate start", 2);

    // R2: no ticks, no progress; then steady ticks
    slow_tick = 1'b0;
    power_on(3'd4, 1'b0);
    repeat (300) @(negedge clk);
    chk("R2 stalled without ticks", int'(core_rst), 1);
    slow_tick = 1'b1;
    check_release("R2 tick count", PW);

    // R7/R11: brown-out in the settling stage with concurrent writes
    power_on(3'd1, 1'b0);
    repeat (BASE + PW + 100) @(negedge clk);
    chk("R7 in settling stage", int'(core_rst), 1);
    bor_req = 1'b1; cause_wr = 1'b1; cause_wdata = 2'b11;
    repeat (4) @(negedge clk);
    bor_req = 1'b0; cause_wr = 1'b0;
    count_high(n);
    chk("R7 restart latency", n, BASE + PW + OS);
    chk("R11 reset beats write", int'(cause), 1);
    chk("R8 done after restart", int'(seq_done), 1);

    finish_run();
  end
endmodule